// File: doc/BRIEF.md
# Two-Wire Bus Line Deglitch Filter

This block sits between the raw clock and data pins of a two-wire serial bus and the protocol logic of a bus master. Each line is first brought into the system clock domain by two flip-flops. It then passes through a stability filter. The filter holds the last accepted level until the synchronized input has kept a new level for a set number of system clocks. Shorter spikes, such as bus noise or ringing, never reach the protocol logic.

Each line output is two bits: bit 0 is the current filtered level and bit 1 is the filtered level one cycle earlier. Downstream logic can find rising and falling edges and detect start and stop conditions without a register of its own.

A build-time parameter selects one of two filters:
- **Fixed mode** uses a sample window of constant length. The output changes only when all the samples in the window agree.
- **Dynamic mode** uses a down-counter. The counter is reloaded from a runtime length input, so the required stability time can be changed while the block runs.

Both lines use the same logic and are filtered independently.

Top module: `twl_deglitch`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, both `scl_filt` and `sda_filt` read 2'b11 (idle bus). This holds whatever the raw inputs are.
- R2: While `enable` is sampled low, both outputs read 2'b11 from the next edge onward, and all samples already in flight are discarded. After `enable` returns high, a low raw level needs the full latency again before it appears.
- R3: In fixed mode (`DYNAMIC`=0), a raw level held for at least `WIN_LEN` clocks is adopted. Bit 0 takes the new value at the `WIN_LEN`+3-th rising edge, counting the first edge that samples the new raw level as edge 1.
- R4: In fixed mode, a raw level held for fewer than `WIN_LEN` clocks leaves bit 0 unchanged.
- R5: In dynamic mode (`DYNAMIC`=1) with length value F, a raw level held for at least F+1 clocks is adopted at edge F+3, counted in the same way.
- R6: In dynamic mode, a raw level held for F clocks or fewer is ignored. Any return to the accepted level before adoption restarts the count from F.
- R7: In dynamic mode with F=0, a single-clock raw pulse is passed through, delayed by the synchronizer plus one register. Bit 0 shows it after edge 3 and drops after edge 4.
- R8: Bit 1 of each output equals bit 0 of the same output one clock earlier, whenever the block was out of reset and enabled on that earlier edge.
- R9: The two lines are independent: a transition on `sda_raw` never changes `scl_filt`, and the reverse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Filter enable; low forces the idle level |
| filt_len | input | CNT_W | Stability length F for dynamic mode (unused in fixed mode) |
| scl_raw | input | 1 | Unsynchronized clock-line input |
| sda_raw | input | 1 | Unsynchronized data-line input |
| scl_filt | output | 2 | Clock line: bit 0 current filtered level, bit 1 previous |
| sda_filt | output | 2 | Data line: bit 0 current filtered level, bit 1 previous |

## Verification
Some properties are checked on every cycle:
- In fixed mode, a filtered level change is always preceded by a unanimous window.
- In dynamic mode, a change only ever follows an expired counter.
- The previous-level bit always trails the current one.
- A disabled block always shows the idle pair.

The bench scenarios are needed for the rest:
- the exact adoption latency in each mode;
- the pulse lengths on either side of the rejection threshold;
- the count restarting after a bounce;
- the zero-length pass-through;
- the two lines not disturbing each other.

// File: rtl/twl_pkg.sv
// Shared constants and types for the two-wire line deglitch filter.
package twl_pkg;
    localparam int NUM_LINES = 2;
    localparam int LINE_SCL  = 0;
    localparam int LINE_SDA  = 1;

    // Filtered level pair: current level and the level one cycle earlier.
    typedef struct packed {
        logic prev;
        logic cur;
    } twl_lvl_t;
endpackage

// File: rtl/twl_sync.sv
// Two-flop synchronizer for one raw bus line.
// Assumes: the raw input is asynchronous to clk. Reset or enable low
// loads the idle level (1) into both stages.
module twl_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic din,
    output logic dout
);
    logic meta_q;
    logic sync_q;

    // Two-stage capture of the raw level, forced idle when off.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
        end
    end

    assign dout = sync_q;
endmodule

// File: rtl/twl_win_filter.sv
// Fixed-window stability filter for one synchronized line.
// Assumes: WIN_LEN >= 2. The level flips only when every sample in the
// window agrees; mixed windows hold the last accepted level.
module twl_win_filter #(
    parameter int WIN_LEN = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic           din,
    output twl_pkg::twl_lvl_t lvl
);
    localparam int MSB = WIN_LEN - 1;

    logic [MSB:0] win_q;
    logic         cur_q;
    logic         prev_q;

    // Shift samples into the window and update the level on unanimity.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            win_q  <= '1;
            cur_q  <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            win_q  <= {win_q[MSB-1:0], din};
            prev_q <= cur_q;
            if (&win_q)
                cur_q <= 1'b1;
            else if (~|win_q)
                cur_q <= 1'b0;
        end
    end

    assign lvl.cur  = cur_q;
    assign lvl.prev = prev_q;

    AST_WIN_UNANIMOUS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(en) && (cur_q != $past(cur_q)))
            |-> ($past(win_q) == {WIN_LEN{cur_q}})); // R4
endmodule

// File: rtl/twl_cnt_filter.sv
// Runtime-length stability filter for one synchronized line.
// Assumes: filt_len is quasi-static. Any sample equal to the accepted
// level reloads the counter; a mismatch seen with the counter at zero
// adopts the new level.
module twl_cnt_filter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] filt_len,
    input  logic             din,
    output twl_pkg::twl_lvl_t lvl
);
    logic [CNT_W-1:0] cnt_q;
    logic             cur_q;
    logic             prev_q;

    // Count down while the input disagrees; adopt the new level at zero.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q  <= '0;
            cur_q  <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            prev_q <= cur_q;
            if (din == cur_q) begin
                cnt_q <= filt_len;
            end else if (cnt_q == '0) begin
                cur_q <= din;
                cnt_q <= filt_len;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign lvl.cur  = cur_q;
    assign lvl.prev = prev_q;

    AST_CNT_EXPIRED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(en) && (cur_q != $past(cur_q)))
            |-> ($past(cnt_q) == '0)); // R6
endmodule

// File: rtl/twl_deglitch.sv
// Two-wire bus line deglitch filter: synchronizes and filters the clock
// and data lines independently and presents current/previous levels.
// Assumes: DYNAMIC selects the counter filter (1) or the fixed window (0).
module twl_deglitch #(
    parameter int WIN_LEN = 4,
    parameter int CNT_W   = 4,
    parameter bit DYNAMIC = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CNT_W-1:0] filt_len,
    input  logic             scl_raw,
    input  logic             sda_raw,
    output logic [1:0]       scl_filt,
    output logic [1:0]       sda_filt
);
    import twl_pkg::*;

    logic     [NUM_LINES-1:0] raw_vec;
    logic     [NUM_LINES-1:0] sync_vec;
    twl_lvl_t                 lvl_vec [NUM_LINES];

    assign raw_vec[LINE_SCL] = scl_raw;
    assign raw_vec[LINE_SDA] = sda_raw;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        twl_sync u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .en   (enable),
            .din  (raw_vec[i]),
            .dout (sync_vec[i])
        );
        if (DYNAMIC) begin : g_cnt
            twl_cnt_filter #(.CNT_W(CNT_W)) u_filt (
                .clk     (clk),
                .rst_n   (rst_n),
                .en      (enable),
                .filt_len(filt_len),
                .din     (sync_vec[i]),
                .lvl     (lvl_vec[i])
            );
        end else begin : g_win
            logic unused_len;
            assign unused_len = ^filt_len;
            twl_win_filter #(.WIN_LEN(WIN_LEN)) u_filt (
                .clk  (clk),
                .rst_n(rst_n),
                .en   (enable),
                .din  (sync_vec[i]),
                .lvl  (lvl_vec[i])
            );
        end
    end

    assign scl_filt = {lvl_vec[LINE_SCL].prev, lvl_vec[LINE_SCL].cur};
    assign sda_filt = {lvl_vec[LINE_SDA].prev, lvl_vec[LINE_SDA].cur};

    AST_OFF_IS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(enable) |-> (scl_filt == 2'b11 && sda_filt == 2'b11)); // R2

    AST_PREV_TRAILS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(enable))
            |-> (scl_filt[1] == $past(scl_filt[0]) &&
                 sda_filt[1] == $past(sda_filt[0]))); // R8
endmodule

// File: tb/tb_twl_deglitch.sv
`timescale 1ns/1ps
module tb_twl_deglitch;
    localparam int W  = 4;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b1;
    logic [CW-1:0] filt_len = 4'd5;
    logic          scl_raw = 1'b1;
    logic          sda_raw = 1'b1;
    logic [1:0]    scl_f, sda_f, scl_d, sda_d;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    twl_deglitch #(.WIN_LEN(W), .CNT_W(CW), .DYNAMIC(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .filt_len(filt_len),
        .scl_raw(scl_raw), .sda_raw(sda_raw), .scl_filt(scl_f), .sda_filt(sda_f));

    twl_deglitch #(.WIN_LEN(W), .CNT_W(CW), .DYNAMIC(1'b1)) dut_dyn (
        .clk(clk), .rst_n(rst_n), .enable(enable), .filt_len(filt_len),
        .scl_raw(scl_raw), .sda_raw(sda_raw), .scl_filt(scl_d), .sda_filt(sda_d));

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic settle_high();
        scl_raw = 1'b1; sda_raw = 1'b1;
        tick(24);
    endtask

    task automatic t_reset();
        scl_raw = 1'b0; sda_raw = 1'b0;
        tick(3);
        chk("R1 fixed scl", scl_f, 2'b11);
        chk("R1 fixed sda", sda_f, 2'b11);
        chk("R1 dyn scl", scl_d, 2'b11);
        scl_raw = 1'b1; sda_raw = 1'b1;
        tick(1);
        rst_n = 1'b1;
        tick(2);
    endtask

    task automatic t_fix_accept();
        scl_raw = 1'b0;
        tick(W + 2);
        chk("R3 before adopt", {1'b0, scl_f[0]}, 2'b01);
        tick(1);
        chk("R3 adopt edge", scl_f, 2'b10);
        tick(1);
        chk("R8 prev follows", scl_f, 2'b00);
    endtask

    task automatic t_fix_reject();
        logic moved = 1'b0;
        scl_raw = 1'b1;
        tick(W - 1);
        scl_raw = 1'b0;
        for (int k = 0; k < 14; k++) begin
            tick(1);
            if (scl_f[0] !== 1'b0) moved = 1'b1;
        end
        chk("R4 short pulse ignored", {1'b0, moved}, 2'b00);
        scl_raw = 1'b1;
        tick(W);
        scl_raw = 1'b0;
        tick(W + 3 - W - 1);
        chk("R3 pulse of WIN_LEN not yet", {1'b0, scl_f[0]}, 2'b00);
        tick(1);
        chk("R3 pulse of WIN_LEN taken", {1'b0, scl_f[0]}, 2'b01);
        tick(16);
    endtask

    task automatic t_independent();
        logic disturbed = 1'b0;
        sda_raw = 1'b0;
        for (int k = 0; k < W + 6; k++) begin
            tick(1);
            if (scl_f !== 2'b00 || scl_d[0] !== 1'b0) disturbed = 1'b1;
        end
        chk("R9 sda adopted", sda_f, 2'b00);
        chk("R9 scl untouched", {1'b0, disturbed}, 2'b00);
        sda_raw = 1'b1;
        tick(W + 6);
    endtask

    task automatic t_enable();
        enable = 1'b0;
        tick(1);
        chk("R2 disabled idle scl", scl_f, 2'b11);
        chk("R2 disabled idle dyn", scl_d, 2'b11);
        tick(3);
        enable = 1'b1;
        tick(W + 2);
        chk("R2 restart latency", {1'b0, scl_f[0]}, 2'b01);
        tick(1);
        chk("R2 relearned low", {1'b0, scl_f[0]}, 2'b00);
        tick(12);
    endtask

    task automatic t_dyn_latency();
        filt_len = 4'd5;
        settle_high();
        scl_raw = 1'b0;
        tick(5 + 2);
        chk("R5 before adopt", {1'b0, scl_d[0]}, 2'b01);
        tick(1);
        chk("R5 adopt edge F+3", scl_d, 2'b10);
        tick(4);
    endtask

    task automatic t_dyn_reject();
        logic moved = 1'b0;
        scl_raw = 1'b1;
        tick(5);
        scl_raw = 1'b0;
        for (int k = 0; k < 14; k++) begin
            tick(1);
            if (scl_d[0] !== 1'b0) moved = 1'b1;
        end
        chk("R6 pulse of F ignored", {1'b0, moved}, 2'b00);
        moved = 1'b0;
        scl_raw = 1'b1;
        tick(4);
        scl_raw = 1'b0;
        tick(1);
        scl_raw = 1'b1;
        for (int k = 0; k < 7; k++) begin
            tick(1);
            if (scl_d[0] !== 1'b0) moved = 1'b1;
        end
        chk("R6 bounce restarts count", {1'b0, moved}, 2'b00);
        tick(1);
        chk("R6 adopt after restart", {1'b0, scl_d[0]}, 2'b01);
        scl_raw = 1'b0;
        tick(16);
    endtask

    task automatic t_dyn_zero();
        filt_len = 4'd0;
        tick(4);
        scl_raw = 1'b1;
        tick(1);
        scl_raw = 1'b0;
        tick(1);
        chk("R7 not before edge 3", {1'b0, scl_d[0]}, 2'b00);
        tick(1);
        chk("R7 pulse passes", {1'b0, scl_d[0]}, 2'b01);
        tick(1);
        chk("R7 pulse ends", scl_d, 2'b10);
    endtask

    initial begin
        #(5.0 * 100000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(1);
        t_reset();
        t_fix_accept();
        t_fix_reject();
        t_independent();
        t_enable();
        t_dyn_latency();
        t_dyn_reject();
        t_dyn_zero();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule